// File: doc/BRIEF.md
# Central Bus Grant and Interrupt Priority Arbiter

This block decides who owns a shared synchronous system bus. One CPU and a parameterised number of I/O or DMA controllers share the bus. Each controller has a request line and a grant line. The CPU has a grant line but no request line, because it is the default owner: it holds the bus whenever no controller needs it. Controllers always outrank the CPU. Among controllers, a lower index means a higher priority. A controller that holds the bus keeps it for as long as its request stays high. A single lock input, driven by the current owner, freezes the grant so that a read-modify-write sequence finishes without another master getting in.

A separate path resolves device interrupts. Each pending line is masked by a per-device enable register. The lowest-numbered enabled pending device, which is the most time-critical one, is reported to the CPU as a valid flag plus a binary identifier. Both paths are registered, so every change appears on a rising bus-clock edge.

Top module: `sysbus_arbiter`

## Requirements
- R1: While reset is held and at its release, `cpu_gnt` is 1, `io_gnt` is 0, `irq_valid` is 0 and `irq_id` is 0. Reset is synchronous and active low.
- R2: Exactly one bit of {`io_gnt`, `cpu_gnt`} is 1 in every cycle.
- R3: If `lock` is 0 and any `io_req` bit is 1 at a rising edge, `cpu_gnt` is 0 after that edge. When a new controller is chosen, the one with the lowest requesting index gets `io_gnt[i]`.
- R4: If `lock` is 0 and `io_req` is all zero at a rising edge, `cpu_gnt` is 1 after that edge.
- R5: A controller that owns the bus keeps its grant across every edge at which its own request is 1, even when a lower-index controller is requesting.
- R6: The grant moves away from a controller at the first rising edge at which its request is sampled 0, and only on a rising edge of `clk`.
- R7: If `lock` is 1 at a rising edge, the grant after that edge equals the grant before it, whatever the requests are. This applies to both a CPU owner and a controller owner.
- R8: One edge after `irq_pend & enable` is sampled non-zero, `irq_valid` is 1 and `irq_id` is the index of the lowest set bit. Index 0 is the most urgent.
- R9: One edge after no enabled interrupt is pending, `irq_valid` is 0 and `irq_id` is 0.
- R10: The enable register resets to all ones. When `irq_en_we` is 1 at an edge, the register loads `irq_en_wdata`. A 0 in bit i hides device i from the selection from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_req | input | NUM_IO | Bus requests from the I/O controllers |
| lock | input | 1 | Owner holds the bus for a read-modify-write sequence |
| cpu_gnt | output | 1 | CPU owns the bus |
| io_gnt | output | NUM_IO | One-hot controller grant |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en_we | input | 1 | Load strobe for the interrupt enable register |
| irq_en_wdata | input | NUM_IRQ | New enable mask |
| irq_valid | output | 1 | An enabled interrupt is pending |
| irq_id | output | clog2(NUM_IRQ) | Index of the winning interrupt |

## Verification
The assertions assume that `lock` is driven only by the current owner, and that the request and pending lines are synchronous to `clk`. Under those assumptions, every property is stated purely on sampled inputs and the next-cycle grant or interrupt output. The stimulus changes every input only on falling edges. It raises `lock` only on sequences where the owner is meant to keep the bus, which includes locked cycles during which a higher-priority controller requests.

// File: rtl/sba_pkg.sv
// Shared definitions for the system bus arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sba_pkg;
    localparam int unsigned SBA_IO_DEFAULT  = 4;
    localparam int unsigned SBA_IRQ_DEFAULT = 8;

    // Decision taken by the grant controller at each bus-clock edge
    typedef enum logic [1:0] {
        DEC_LOCK = 2'd0,
        DEC_HOLD = 2'd1,
        DEC_IO   = 2'd2,
        DEC_CPU  = 2'd3
    } arb_decision_e;
endpackage

// File: rtl/sba_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
// Purely combinational. Assumes N >= 1.
module sba_prio_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot,
    output logic         any
);
    // Scan from the top so the lowest set index is written last
    always_comb begin
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/sba_grant_ctrl.sv
// Bus grant register. The CPU is the default owner. Controllers outrank
// the CPU and keep the bus while they request. Lock freezes the grant.
// Assumes lock is driven only by the present owner.
module sba_grant_ctrl
    import sba_pkg::*;
#(
    parameter int unsigned NUM_IO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IO-1:0] io_req,
    input  logic              lock,
    output logic              cpu_gnt,
    output logic [NUM_IO-1:0] io_gnt
);
    localparam int unsigned GW = NUM_IO + 1;
    localparam logic [GW-1:0] CPU_ONLY = {1'b1, {NUM_IO{1'b0}}};

    logic [GW-1:0]     gnt_q;
    logic [GW-1:0]     gnt_d;
    logic [NUM_IO-1:0] pick_oh;
    logic              pick_any;
    logic              owner_req;
    arb_decision_e     dec;

    sba_prio_pick #(.N(NUM_IO)) u_pick (
        .req    (io_req),
        .onehot (pick_oh),
        .any    (pick_any)
    );

    // Choose how the next owner is found
    always_comb begin
        owner_req = |(gnt_q[NUM_IO-1:0] & io_req);
        if (lock)            dec = DEC_LOCK;
        else if (owner_req)  dec = DEC_HOLD;
        else if (pick_any)   dec = DEC_IO;
        else                 dec = DEC_CPU;
    end

    // Form the next grant vector from the decision
    always_comb begin
        case (dec)
            DEC_LOCK, DEC_HOLD: gnt_d = gnt_q;
            DEC_IO:             gnt_d = {1'b0, pick_oh};
            default:            gnt_d = CPU_ONLY;
        endcase
    end

    // Grant register, changing only on bus-clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= CPU_ONLY;
        else        gnt_q <= gnt_d;
    end

    assign cpu_gnt = gnt_q[NUM_IO];
    assign io_gnt  = gnt_q[NUM_IO-1:0];
endmodule

// File: rtl/sba_irq_sel.sv
// Interrupt priority selector with a per-device enable register.
// Lowest enabled pending index wins. The output is registered every cycle.
// Assumes pending lines are synchronous to clk.
module sba_irq_sel #(
    parameter int unsigned NUM_IRQ = 8,
    localparam int unsigned IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               irq_en_we,
    input  logic [NUM_IRQ-1:0] irq_en_wdata,
    output logic               irq_valid,
    output logic [IDW-1:0]     irq_id
);
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] win_oh;
    logic               win_any;
    logic [IDW-1:0]     win_idx;

    sba_prio_pick #(.N(NUM_IRQ)) u_pick (
        .req    (irq_pend & en_q),
        .onehot (win_oh),
        .any    (win_any)
    );

    // Encode the one-hot winner into a binary identifier
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (win_oh[i]) win_idx = win_idx | IDW'(i);
        end
    end

    // Enable register, loaded by its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '1;
        else if (irq_en_we) en_q <= irq_en_wdata;
    end

    // Registered interrupt report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
        end else begin
            irq_valid <= win_any;
            irq_id    <= win_idx;
        end
    end
endmodule

// File: rtl/sysbus_arbiter.sv
// Top level: central bus arbiter plus interrupt priority selector.
// Both paths are independent and share only clock and reset.
module sysbus_arbiter
    import sba_pkg::*;
#(
    parameter int unsigned NUM_IO  = SBA_IO_DEFAULT,
    parameter int unsigned NUM_IRQ = SBA_IRQ_DEFAULT,
    localparam int unsigned IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IO-1:0]  io_req,
    input  logic               lock,
    output logic               cpu_gnt,
    output logic [NUM_IO-1:0]  io_gnt,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               irq_en_we,
    input  logic [NUM_IRQ-1:0] irq_en_wdata,
    output logic               irq_valid,
    output logic [IDW-1:0]     irq_id
);
    sba_grant_ctrl #(.NUM_IO(NUM_IO)) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_req  (io_req),
        .lock    (lock),
        .cpu_gnt (cpu_gnt),
        .io_gnt  (io_gnt)
    );

    sba_irq_sel #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pend     (irq_pend),
        .irq_en_we    (irq_en_we),
        .irq_en_wdata (irq_en_wdata),
        .irq_valid    (irq_valid),
        .irq_id       (irq_id)
    );
endmodule

// File: rtl/sysbus_arbiter_chk.sv
// Property checker for sysbus_arbiter, attached with bind.
module sysbus_arbiter_chk #(
    parameter int unsigned NUM_IO  = 4,
    parameter int unsigned NUM_IRQ = 8,
    localparam int unsigned IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IO-1:0]  io_req,
    input logic               lock,
    input logic               cpu_gnt,
    input logic [NUM_IO-1:0]  io_gnt,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic               irq_valid,
    input logic [IDW-1:0]     irq_id
);
    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({io_gnt, cpu_gnt}));

    // R3
    io_beats_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && (io_req != '0)) |=> !cpu_gnt);

    // R4
    cpu_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && (io_req == '0)) |=> cpu_gnt);

    // R5
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && ((io_gnt & io_req) != '0)) |=> $stable(io_gnt));

    // R7
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(io_gnt) && $stable(cpu_gnt)));

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend == '0) |=> (!irq_valid && irq_id == '0));
endmodule

bind sysbus_arbiter sysbus_arbiter_chk #(.NUM_IO(NUM_IO), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_req    (io_req),
    .lock      (lock),
    .cpu_gnt   (cpu_gnt),
    .io_gnt    (io_gnt),
    .irq_pend  (irq_pend),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
);

// File: tb/sysbus_arbiter_tb.sv
`timescale 1ns/1ps
module sysbus_arbiter_tb;
    localparam int NIO  = 4;
    localparam int NIRQ = 8;
    localparam int NVEC = 14;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NIO-1:0]  io_req;
    logic            lock;
    logic            cpu_gnt;
    logic [NIO-1:0]  io_gnt;
    logic [NIRQ-1:0] irq_pend;
    logic            irq_en_we;
    logic [NIRQ-1:0] irq_en_wdata;
    logic            irq_valid;
    logic [2:0]      irq_id;

    int vec_cnt  = 0;
    int miss_cnt = 0;

    always #2.5 clk = ~clk;

    sysbus_arbiter #(.NUM_IO(NIO), .NUM_IRQ(NIRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .lock(lock),
        .cpu_gnt(cpu_gnt), .io_gnt(io_gnt), .irq_pend(irq_pend),
        .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    // Vector: {io_req[3:0], lock, expected {io_gnt[3:0], cpu_gnt}}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b0000, 1'b0, 5'b00001},  // R4 idle -> CPU
        {4'b0100, 1'b0, 5'b01000},  // R3 controller 2 beats CPU
        {4'b0101, 1'b0, 5'b01000},  // R5 owner keeps bus vs index 0
        {4'b0001, 1'b0, 5'b00010},  // R6 owner dropped -> index 0
        {4'b0001, 1'b1, 5'b00010},  // R7 locked hold
        {4'b1000, 1'b1, 5'b00010},  // R7 lock holds after request drop
        {4'b1010, 1'b0, 5'b00100},  // R3 lowest index of 1 and 3
        {4'b0000, 1'b0, 5'b00001},  // R4 back to CPU
        {4'b0000, 1'b1, 5'b00001},  // R7 CPU lock
        {4'b0001, 1'b1, 5'b00001},  // R7 lock blocks higher priority
        {4'b0001, 1'b0, 5'b00010},  // R3 lock released
        {4'b1100, 1'b0, 5'b01000},  // R6 re-arbitrate to index 2
        {4'b1000, 1'b0, 5'b10000},  // R6 then index 3
        {4'b0000, 1'b0, 5'b00001}   // R4 idle again
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        miss_cnt++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        rst_n = 1'b0; io_req = '0; lock = 1'b0;
        irq_pend = '0; irq_en_we = 1'b0; irq_en_wdata = '0;
        step(); step();
        // R1 reset state
        check("R1 grant", {27'd0, io_gnt, cpu_gnt}, 32'h1);
        check("R1 irq", {28'd0, irq_valid, irq_id}, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            io_req = VEC[k][9:6];
            lock   = VEC[k][5];
            step();
            check($sformatf("R3/R4/R5/R6/R7 vec %0d", k),
                  {27'd0, io_gnt, cpu_gnt}, {27'd0, VEC[k][4:0]});
            check($sformatf("R2 vec %0d", k), $countones({io_gnt, cpu_gnt}), 1);
        end
        lock = 1'b0; io_req = '0;

        // R10 enable resets to all ones: bit 0 visible
        irq_pend = 8'h01; step();
        check("R10 reset enable", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd0});
        // R8 priority selection
        irq_pend = 8'hA0; step();
        check("R8 id5", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd5});
        irq_pend = 8'hA4; step();
        check("R8 id2", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd2});
        irq_pend = 8'h80; step();
        check("R8 id7", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd7});
        // R10 mask device 2: the load edge still reports the old mask
        irq_pend = 8'hA4; irq_en_we = 1'b1; irq_en_wdata = 8'hFB; step();
        check("R10 load edge", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd2});
        irq_en_we = 1'b0; step();
        check("R10 masked", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd5});
        irq_pend = 8'h04; step();
        check("R10 only masked pending", {28'd0, irq_valid, irq_id}, 32'h0);
        // R9 nothing pending
        irq_pend = 8'h00; step();
        check("R9 idle", {28'd0, irq_valid, irq_id}, 32'h0);

        // R1 reset in the middle of a controller tenure, with lock high
        io_req = 4'b0010; step();
        check("R3 pre-reset", {27'd0, io_gnt, cpu_gnt}, 32'h4);
        irq_pend = 8'h10; step();
        rst_n = 1'b0; lock = 1'b1; step();
        check("R1 mid-run grant", {27'd0, io_gnt, cpu_gnt}, 32'h1);
        check("R1 mid-run irq", {28'd0, irq_valid, irq_id}, 32'h0);
        rst_n = 1'b1; lock = 1'b0; io_req = '0; irq_pend = '0; step();
        check("R4 after reset", {27'd0, io_gnt, cpu_gnt}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end
endmodule